// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Error Status

This block takes in serial characters and places each completed one into a single receive holding register. It has two modes. In asynchronous mode the line idles high. Each character opens with a low start bit, carries 7, 8 or 9 data bits least significant bit first, may carry a parity bit, and closes with a stop bit. The line is sampled on a 16x oversampling tick. In clocked synchronous mode, data bits are captured on rising edges of an external serial clock. There are no framing bits in this mode.

Next to the holding register the block keeps a status byte with four sticky flags: overrun, parity error, framing error and error summary. Software drains the holding register by pulsing a read strobe for its low byte. That strobe normally clears the buffer-full flag and the error flags. While an overrun is pending, the strobe still empties the buffer, but the error flags stay set until receive enable is dropped. Dropping receive enable also aborts any character in progress.

Top module: `sio_rx_core`

## Requirements
- R1: In asynchronous mode, a falling line starts a character only if the line is still low 8 ticks later. After that, every 16 ticks one bit is captured, least significant bit first. The character-length code selects the number of data bits: 0 gives 7, 1 gives 8, and 2 or 3 give 9. The completed data appears on `rx_data` zero-extended, and `buf_full` goes high.
- R2: In synchronous mode (`mode_sync`=1), one bit is captured per rising edge of `sclk`. The selected number of data bits makes up a character, and the parity and framing flags always stay 0.
- R3: With `par_en`=1, a parity bit follows the data bits. If the data plus parity do not have an even number of ones (`par_odd`=0) or an odd number of ones (`par_odd`=1), status bit 5 is set.
- R4: Status bit 6 is set when the sampled stop bit of an asynchronous character is low.
- R5: Status bit 7 is set whenever any of bits 4, 5 or 6 is set. Status bits 3 to 0 read 0.
- R6: If a character completes while `buf_full` is high and no read strobe is present, the character is discarded, `rx_data` is kept, and status bits 4 and 7 are set.
- R7: A `rd_low` pulse with no overrun pending clears `buf_full` and status bits 5, 6 and 7.
- R8: While bit 4 is set, `rd_low` clears `buf_full` but leaves status bits 4 to 7 unchanged. A later character is accepted, and the flags stay set.
- R9: With `rx_en` low, all status flags clear and a partly received character is dropped. Reception resumes cleanly after `rx_en` returns high.
- R10: A low pulse on the idle line that is gone at the 8-tick confirmation point starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low clears flags and aborts reception |
| mode_sync | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| par_en | input | 1 | Parity bit present and checked (asynchronous) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| char_len | input | 2 | Data bits: 0=7, 1=8, 2/3=9 |
| samp_tick | input | 1 | 16x bit-rate enable |
| rxd | input | 1 | Serial data line |
| sclk | input | 1 | Serial clock for synchronous mode |
| rd_low | input | 1 | Strobe marking a read of the buffer low byte |
| rx_data | output | 9 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread character |
| rx_status | output | 8 | Bit7 summary, bit6 framing, bit5 parity, bit4 overrun |

## Verification
The hardest state to reach is an overrun that lands on a buffer whose character already carries a parity error. Only in that state does the blocked read show, because the flags must survive a strobe that would otherwise clear them. The stimulus sends a bad-parity character and leaves it unread. It then sends a second character to cause the overrun, reads, and sends a third character so that acceptance alongside the sticky flags can be seen. The stimulus then drops enable for one cycle and checks that everything clears.

// File: rtl/sio_rx_pkg.sv
`timescale 1ns/1ps
package sio_rx_pkg;

    localparam int unsigned MAX_DATA  = 9;
    localparam int unsigned FRAME_MAX = MAX_DATA + 2;

    localparam int unsigned ST_OVR = 4;
    localparam int unsigned ST_PAR = 5;
    localparam int unsigned ST_FRM = 6;
    localparam int unsigned ST_SUM = 7;

    typedef enum logic [1:0] {
        LEN_7 = 2'd0,
        LEN_8 = 2'd1,
        LEN_9 = 2'd2
    } char_len_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS
    } rx_state_e;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                par_err;
        logic                frm_err;
    } rx_char_t;

    function automatic int data_bits(input logic [1:0] len);
        case (len)
            LEN_7:   return 7;
            LEN_8:   return 8;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
    import sio_rx_pkg::*;
#(
    parameter int unsigned OVSAMP = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       mode_sync,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] char_len,
    input  logic       samp_tick,
    input  logic       rxd_s,
    input  logic       sclk_s,
    output logic       done,
    output rx_char_t   chr
);
    localparam int unsigned CW   = $clog2(OVSAMP);
    localparam int unsigned HALF = OVSAMP / 2;
    localparam int unsigned IW   = $clog2(FRAME_MAX + 1);

    rx_state_e              state;
    logic [CW-1:0]          cnt;
    logic [IW-1:0]          idx;
    logic [FRAME_MAX-1:0]   sr;
    logic                   sclk_q;

    int                     nb;
    int                     tot;
    logic                   sclk_rise;
    logic [FRAME_MAX-1:0]   fr_next;
    logic [MAX_DATA-1:0]    dmask;
    logic                   pbit, sbit;
    logic                   last_async, last_sync;
    rx_char_t               chr_next;

    always_comb begin
        nb        = data_bits(char_len);
        tot       = nb + (par_en ? 1 : 0) + 1;
        sclk_rise = sclk_s & ~sclk_q;
        fr_next   = sr;
        fr_next[idx] = rxd_s;
        dmask = '0;
        pbit  = 1'b0;
        sbit  = 1'b1;
        for (int i = 0; i < int'(FRAME_MAX); i++) begin
            if (i < nb && i < int'(MAX_DATA)) dmask[i] = fr_next[i];
            if (i == nb) pbit = fr_next[i];
            if (i == tot - 1) sbit = fr_next[i];
        end
        last_async = (state == ST_BITS) && samp_tick &&
                     (cnt == CW'(OVSAMP - 1)) && (idx == IW'(tot - 1));
        last_sync  = sclk_rise && (idx == IW'(nb - 1));
        chr_next.data    = dmask;
        chr_next.par_err = !mode_sync && par_en && ((^dmask ^ pbit) != par_odd);
        chr_next.frm_err = !mode_sync && !sbit;
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            sr     <= '0;
            done   <= 1'b0;
            chr    <= '0;
            sclk_q <= rst ? 1'b0 : sclk_s;
        end else begin
            done   <= 1'b0;
            sclk_q <= sclk_s;
            if (mode_sync) begin
                state <= ST_IDLE;
                cnt   <= '0;
                if (sclk_rise) begin
                    sr <= fr_next;
                    if (last_sync) begin
                        done <= 1'b1;
                        chr  <= chr_next;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (samp_tick && !rxd_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                            idx   <= '0;
                        end
                    end
                    ST_START: begin
                        if (samp_tick) begin
                            if (cnt == CW'(HALF - 1)) begin
                                cnt   <= '0;
                                state <= rxd_s ? ST_IDLE : ST_BITS;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_BITS: begin
                        if (samp_tick) begin
                            if (cnt == CW'(OVSAMP - 1)) begin
                                cnt <= '0;
                                sr  <= fr_next;
                                if (last_async) begin
                                    done  <= 1'b1;
                                    chr   <= chr_next;
                                    state <= ST_IDLE;
                                    idx   <= '0;
                                end else begin
                                    idx <= idx + 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                           // R1
    AST_SYNC_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mode_sync)) |-> (!chr.par_err && !chr.frm_err)); // R2
endmodule

// File: rtl/rx_status.sv
`timescale 1ns/1ps
module rx_status
    import sio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic                rd_low,
    input  logic                done,
    input  rx_char_t            chr,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                buf_full,
    output logic                ovr,
    output logic                par,
    output logic                frm,
    output logic                sum
);
    logic keep, full0, p0, f0, s0;
    logic full_n, ovr_n, par_n, frm_n, sum_n, load;

    always_comb begin
        keep  = ovr || !rd_low;
        full0 = buf_full && !rd_low;
        p0    = keep && par;
        f0    = keep && frm;
        s0    = keep && sum;
        full_n = full0;
        ovr_n  = ovr;
        par_n  = p0;
        frm_n  = f0;
        sum_n  = s0;
        load   = 1'b0;
        if (done) begin
            if (full0) begin
                ovr_n = 1'b1;
                sum_n = 1'b1;
            end else begin
                load   = 1'b1;
                full_n = 1'b1;
                par_n  = p0 | chr.par_err;
                frm_n  = f0 | chr.frm_err;
                sum_n  = s0 | chr.par_err | chr.frm_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            buf_full <= 1'b0;
            ovr      <= 1'b0;
            par      <= 1'b0;
            frm      <= 1'b0;
            sum      <= 1'b0;
        end else if (!rx_en) begin
            ovr <= 1'b0;
            par <= 1'b0;
            frm <= 1'b0;
            sum <= 1'b0;
            if (rd_low) buf_full <= 1'b0;
        end else begin
            if (load) rx_data <= chr.data;
            buf_full <= full_n;
            ovr      <= ovr_n;
            par      <= par_n;
            frm      <= frm_n;
            sum      <= sum_n;
        end
    end

    AST_SUM_COVERS: assert property (@(posedge clk) disable iff (rst)
        (ovr || par || frm) |-> sum);                              // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && rx_en) |=> ovr);                                   // R6
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rd_low && !ovr && !done) |=> (!buf_full && !sum)); // R7
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rd_low && ovr && par) |=> (par && sum && ovr));  // R8
    AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !(ovr || par || frm || sum));                   // R9
endmodule

// File: rtl/sio_rx_core.sv
`timescale 1ns/1ps
module sio_rx_core
    import sio_rx_pkg::*;
#(
    parameter int unsigned OVSAMP      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       mode_sync,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] char_len,
    input  logic       samp_tick,
    input  logic       rxd,
    input  logic       sclk,
    input  logic       rd_low,
    output logic [8:0] rx_data,
    output logic       buf_full,
    output logic [7:0] rx_status
);
    logic [1:0] line_s;
    logic       done;
    rx_char_t   chr;
    logic       ovr, par, frm, sum;

    rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, rxd}),
        .q   (line_s)
    );

    rx_frame #(.OVSAMP(OVSAMP)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .mode_sync (mode_sync),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .char_len  (char_len),
        .samp_tick (samp_tick),
        .rxd_s     (line_s[0]),
        .sclk_s    (line_s[1]),
        .done      (done),
        .chr       (chr)
    );

    rx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .rd_low   (rd_low),
        .done     (done),
        .chr      (chr),
        .rx_data  (rx_data),
        .buf_full (buf_full),
        .ovr      (ovr),
        .par      (par),
        .frm      (frm),
        .sum      (sum)
    );

    always_comb begin
        rx_status         = '0;
        rx_status[ST_OVR] = ovr;
        rx_status[ST_PAR] = par;
        rx_status[ST_FRM] = frm;
        rx_status[ST_SUM] = sum;
    end
endmodule

// File: tb/test_sio_rx_core.sv
`timescale 1ns/1ps
module test_sio_rx_core;
    logic       clk = 1'b0;
    logic       rst, rx_en, mode_sync, par_en, par_odd, samp_tick, rxd, sclk, rd_low;
    logic [1:0] char_len;
    logic [8:0] rx_data;
    logic       buf_full;
    logic [7:0] rx_status;

    int checks = 0;
    int failures = 0;
    logic bf_prev = 1'b0;

    typedef struct { logic [8:0] d; logic [7:0] s; } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    sio_rx_core i_sio_rx_core (
        .clk(clk), .rst(rst), .rx_en(rx_en), .mode_sync(mode_sync),
        .par_en(par_en), .par_odd(par_odd), .char_len(char_len),
        .samp_tick(samp_tick), .rxd(rxd), .sclk(sclk), .rd_low(rd_low),
        .rx_data(rx_data), .buf_full(buf_full), .rx_status(rx_status)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        cyc(16);
    endtask

    task automatic push(input logic [8:0] d, input logic [7:0] s);
        exp_t e;
        e.d = d;
        e.s = s;
        q.push_back(e);
    endtask

    task automatic send_async(input logic [8:0] d, input int nb, input logic flip,
                              input logic stop);
        logic [8:0] m;
        m = d & ((9'h1 << nb) - 9'h1);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(m[i]);
        if (par_en) hold_bit((^m) ^ par_odd ^ flip);
        hold_bit(stop);
        rxd = 1'b1;
        cyc(10);
    endtask

    task automatic send_sync(input logic [8:0] d, input int nb);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            cyc(2);
            sclk = 1'b1;
            cyc(3);
            sclk = 1'b0;
            cyc(2);
        end
        rxd = 1'b1;
        cyc(6);
    endtask

    task automatic rd();
        rd_low = 1'b1;
        cyc(1);
        rd_low = 1'b0;
    endtask

    // Monitor: compare each newly filled buffer with the next expected item.
    always @(negedge clk) begin
        if (!rst) begin
            if (buf_full && !bf_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1 unexpected character", int'(rx_data), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rx_data == e.d, "R1 data", int'(rx_data), int'(e.d));
                    chk(rx_status == e.s, "R3/R4/R5 status", int'(rx_status), int'(e.s));
                end
            end
            bf_prev <= buf_full;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_en = 1'b0; mode_sync = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        char_len = 2'd1; samp_tick = 1'b1; rxd = 1'b1; sclk = 1'b0; rd_low = 1'b0;
        cyc(5);
        rst = 1'b0;
        rx_en = 1'b1;
        cyc(4);
        @(negedge clk);
        chk(buf_full == 1'b0, "R7 reset buf_full", int'(buf_full), 0);
        chk(rx_status == 8'h00, "R5 reset status", int'(rx_status), 0);
        cyc(1);

        // R1: three character lengths
        push(9'h0A5, 8'h00); send_async(9'h0A5, 8, 1'b0, 1'b1); rd();
        @(negedge clk);
        chk(!buf_full && rx_status == 8'h00, "R7 read clears", int'(rx_status), 0);
        cyc(1);
        char_len = 2'd0;
        push(9'h05A, 8'h00); send_async(9'h0DA, 7, 1'b0, 1'b1); rd();
        char_len = 2'd2;
        push(9'h1C3, 8'h00); send_async(9'h1C3, 9, 1'b0, 1'b1); rd();
        char_len = 2'd1;

        // R3: good even parity, then bad odd parity
        par_en = 1'b1;
        push(9'h033, 8'h00); send_async(9'h033, 8, 1'b0, 1'b1); rd();
        par_odd = 1'b1;
        push(9'h081, 8'hA0); send_async(9'h081, 8, 1'b1, 1'b1); rd();
        @(negedge clk);
        chk(rx_status == 8'h00, "R7 read clears parity", int'(rx_status), 0);
        cyc(1);

        // R4: low stop bit
        par_en = 1'b0; par_odd = 1'b0;
        push(9'h07E, 8'hC0); send_async(9'h07E, 8, 1'b0, 1'b0); rd();
        @(negedge clk);
        chk(rx_status == 8'h00, "R7 read clears framing", int'(rx_status), 0);
        cyc(1);

        // R6/R8: overrun on top of a parity error
        par_en = 1'b1;
        push(9'h011, 8'hA0); send_async(9'h011, 8, 1'b1, 1'b1);
        send_async(9'h022, 8, 1'b0, 1'b1);
        @(negedge clk);
        chk(buf_full == 1'b1, "R6 buffer kept full", int'(buf_full), 1);
        chk(rx_data == 9'h011, "R6 data kept", int'(rx_data), 'h11);
        chk(rx_status == 8'hB0, "R6 overrun status", int'(rx_status), 'hB0);
        cyc(1);
        rd();
        @(negedge clk);
        chk(buf_full == 1'b0, "R8 read empties buffer", int'(buf_full), 0);
        chk(rx_status == 8'hB0, "R8 flags survive read", int'(rx_status), 'hB0);
        cyc(1);
        push(9'h044, 8'hB0); send_async(9'h044, 8, 1'b0, 1'b1);
        rx_en = 1'b0;
        cyc(1);
        rx_en = 1'b1;
        @(negedge clk);
        chk(rx_status == 8'h00, "R9 disable clears flags", int'(rx_status), 0);
        cyc(1);
        rd();

        // R2: synchronous mode, parity setting ignored
        mode_sync = 1'b1;
        push(9'h03C, 8'h00); send_sync(9'h03C, 8); rd();
        mode_sync = 1'b0; par_en = 1'b0;
        cyc(4);

        // R9: abort a partial frame
        hold_bit(1'b0); hold_bit(1'b1); hold_bit(1'b0); hold_bit(1'b1);
        rx_en = 1'b0;
        cyc(2);
        rxd = 1'b1;
        cyc(4);
        rx_en = 1'b1;
        cyc(200);
        @(negedge clk);
        chk(buf_full == 1'b0, "R9 partial frame dropped", int'(buf_full), 0);
        cyc(1);
        push(9'h099, 8'h00); send_async(9'h099, 8, 1'b0, 1'b1); rd();

        // R10: short glitch
        rxd = 1'b0;
        cyc(4);
        rxd = 1'b1;
        cyc(60);
        @(negedge clk);
        chk(buf_full == 1'b0 && rx_status == 8'h00, "R10 glitch ignored",
            int'(buf_full), 0);
        cyc(20);
        chk(q.size() == 0, "R1 all characters seen", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule